// File: doc/BRIEF.md
# Clock-Request Output Gating Controller

This block decides, cycle by cycle, whether each clock output of a clock generator should run or stop, and whether a stopped differential output is parked driven low or released to high impedance. It covers six differential PCIe reference outputs, two graphics clock outputs, three CPU clock pairs and five single-ended outputs (one PCI, one USB and three reference clocks). The oscillators and the analog output stages are outside the block. It only produces one run bit for each output and, for each differential output, one high-impedance bit.

Each PCIe output can be placed under the control of either of two active-low clock-request pins. A per-output master enable overrides the pins. The graphics outputs follow their enable bits alone. A CPU pair stops while the active-low CPU stop pin is asserted, unless it is marked free-running. The request pins and the stop pin are asynchronous, so they pass through a synchroniser. Each run bit is then registered, and it is updated only on edges where the `gate_window` input shows that the output clock is in its low phase. Because of this, a clock pulse is never cut short.

Top module: `clkreq_gate_ctrl`

## Requirements
- R1: When a PCIe lane has request pin A selected (`pcie_sel_a[i]`=1), the lane runs while `req_a_n` is 0 and stops while it is 1.
- R2: A request pin that a lane has not selected has no effect on that lane. Pin B acts on the lanes selected in `pcie_sel_b` in the same way that pin A acts on its lanes.
- R3: A PCIe lane whose `pcie_master_en` bit is 0 is stopped, whatever the request pins read.
- R4: Each graphics output runs exactly when its `gfx_en` bit is 1. The request pins never affect it.
- R5: A stopped differential output (PCIe, graphics or CPU) asserts its `*_hiz` bit only when `park_mode` is 1. With `park_mode` 0 every `*_hiz` bit is 0.
- R6: CPU pair k runs when `cpu_en[k]` is 1 and it is not being stopped. A low `cpu_stop_n` always stops pair 0. It stops pair k (k = 1 or 2) only when `cpu_stop_en[k-1]` is 1. With that bit at 0 the pair is free-running.
- R7: Each single-ended output runs exactly when its `se_en` bit is 1. The bit order is PCI, USB, REF0, REF1 and REF2, from bit 0 upward.
- R8: When a lane selects both pins, it stops if either pin reads 1, and `sel_conflict` is 1 for as long as any lane has both selects set.
- R9: When `gate_window` is held at 1, a change on a request pin or the stop pin appears on the run outputs at the third rising clock edge after it, because of two synchroniser stages and then the run register.
- R10: Run outputs change only on rising edges where `gate_window` is 1. On other edges they hold their value.
- R11: During reset every run output is 0 and the synchronisers read the pins as idle (high). The first open-window edge after reset brings every output to its requested state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_window | input | 1 | 1 while the output clock is in its low phase, which allows a run update |
| req_a_n | input | 1 | Asynchronous clock-request pin A, active low |
| req_b_n | input | 1 | Asynchronous clock-request pin B, active low |
| cpu_stop_n | input | 1 | Asynchronous CPU stop pin, active low |
| pcie_sel_a | input | 6 | Lanes under the control of pin A |
| pcie_sel_b | input | 6 | Lanes under the control of pin B |
| pcie_master_en | input | 6 | Per-lane master enable |
| gfx_en | input | 2 | Graphics output enables |
| park_mode | input | 1 | 0 = stopped differential outputs are driven, 1 = high impedance |
| cpu_en | input | 3 | CPU pair enables |
| cpu_stop_en | input | 2 | Stop-enable for CPU pairs 1 and 2 |
| se_en | input | 5 | Single-ended enables (PCI, USB, REF0, REF1, REF2) |
| pcie_run | output | 6 | PCIe lane run bits |
| pcie_hiz | output | 6 | PCIe lane high-impedance bits |
| gfx_run | output | 2 | Graphics run bits |
| gfx_hiz | output | 2 | Graphics high-impedance bits |
| cpu_run | output | 3 | CPU pair run bits |
| cpu_hiz | output | 3 | CPU pair high-impedance bits |
| se_run | output | 5 | Single-ended run bits |
| sel_conflict | output | 1 | Some lane has both request pins selected |

## Verification
Two functions can fall in the same cycle: a request-pin change finishing its trip through the synchroniser, and a closed low-phase window that forbids any update. The bench provokes this by dropping pin A and changing the single-ended enables while `gate_window` is 0. It checks that both run outputs hold through the closed window, and that both update together on the first edge after the window reopens. A second overlap comes from two selected pins that disagree in the same cycle. This is judged by whether the lane stops while `sel_conflict` is raised.

// File: rtl/clkreq_gate_pkg.sv
package clkreq_gate_pkg;

    // Asynchronous control pins, sampled together through one synchroniser.
    typedef struct packed {
        logic req_a_n;
        logic req_b_n;
        logic cpu_stop_n;
    } pin_set_t;

    localparam int PIN_COUNT = $bits(pin_set_t);

    // Idle pin levels: no request asserted, no stop asserted.
    localparam pin_set_t PIN_IDLE = '{req_a_n: 1'b1, req_b_n: 1'b1, cpu_stop_n: 1'b1};

    typedef enum logic {
        PARK_DRIVEN = 1'b0,
        PARK_HIZ    = 1'b1
    } park_mode_e;

    // A lane runs when it is enabled and no pin that it selects asks it to stop.
    // With both pins selected, a stop request from either pin wins.
    function automatic logic lane_want(input logic sel_a, input logic sel_b,
                                       input logic master_en,
                                       input logic pin_a_n, input logic pin_b_n);
        return master_en & ~(sel_a & pin_a_n) & ~(sel_b & pin_b_n);
    endfunction

    function automatic logic cpu_want(input logic en, input logic stoppable,
                                      input logic stop_now);
        return en & ~(stoppable & stop_now);
    endfunction

endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= RST_VAL;
            else     stage_q[g] <= stage_q[g-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pcie_want_gen.sv
module pcie_want_gen
    import clkreq_gate_pkg::*;
#(
    parameter int LANES = 6
) (
    input  logic [LANES-1:0] sel_a,
    input  logic [LANES-1:0] sel_b,
    input  logic [LANES-1:0] master_en,
    input  logic             pin_a_n,
    input  logic             pin_b_n,
    output logic [LANES-1:0] want,
    output logic             conflict
);
    logic [LANES-1:0] both_sel;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign want[l]     = lane_want(sel_a[l], sel_b[l], master_en[l], pin_a_n, pin_b_n);
        assign both_sel[l] = sel_a[l] & sel_b[l];
    end

    assign conflict = |both_sel;
endmodule

// File: rtl/cpu_want_gen.sv
module cpu_want_gen
    import clkreq_gate_pkg::*;
#(
    parameter int PAIRS = 3
) (
    input  logic [PAIRS-1:0] en,
    input  logic [PAIRS-2:0] stop_en,
    input  logic             stop_now,
    output logic [PAIRS-1:0] want
);
    // Pair 0 always obeys the stop pin; the others follow their stop-enable bit.
    assign want[0] = cpu_want(en[0], 1'b1, stop_now);

    for (genvar p = 1; p < PAIRS; p++) begin : g_pair
        assign want[p] = cpu_want(en[p], stop_en[p-1], stop_now);
    end
endmodule

// File: rtl/gate_run_reg.sv
module gate_run_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             window,
    input  logic [WIDTH-1:0] want,
    output logic [WIDTH-1:0] run
);
    always_ff @(posedge clk) begin
        if (rst)         run <= '0;
        else if (window) run <= want;
    end

    // R10: nothing moves on an edge where the low-phase window is closed
    p_hold_shut_r10: assert property (@(posedge clk) disable iff (rst)
        !window |=> $stable(run));

    // R10: with the window open, the next value is the request seen at that edge
    p_follow_open_r10: assert property (@(posedge clk) disable iff (rst)
        window |=> (run == $past(want)));
endmodule

// File: rtl/clkreq_gate_ctrl.sv
module clkreq_gate_ctrl
    import clkreq_gate_pkg::*;
#(
    parameter int NUM_PCIE    = 6,
    parameter int NUM_GFX     = 2,
    parameter int NUM_CPU     = 3,
    parameter int NUM_SE      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                gate_window,
    input  logic                req_a_n,
    input  logic                req_b_n,
    input  logic                cpu_stop_n,
    input  logic [NUM_PCIE-1:0] pcie_sel_a,
    input  logic [NUM_PCIE-1:0] pcie_sel_b,
    input  logic [NUM_PCIE-1:0] pcie_master_en,
    input  logic [NUM_GFX-1:0]  gfx_en,
    input  logic                park_mode,
    input  logic [NUM_CPU-1:0]  cpu_en,
    input  logic [NUM_CPU-2:0]  cpu_stop_en,
    input  logic [NUM_SE-1:0]   se_en,
    output logic [NUM_PCIE-1:0] pcie_run,
    output logic [NUM_PCIE-1:0] pcie_hiz,
    output logic [NUM_GFX-1:0]  gfx_run,
    output logic [NUM_GFX-1:0]  gfx_hiz,
    output logic [NUM_CPU-1:0]  cpu_run,
    output logic [NUM_CPU-1:0]  cpu_hiz,
    output logic [NUM_SE-1:0]   se_run,
    output logic                sel_conflict
);
    localparam int OFS_PCIE = 0;
    localparam int OFS_GFX  = OFS_PCIE + NUM_PCIE;
    localparam int OFS_CPU  = OFS_GFX + NUM_GFX;
    localparam int OFS_SE   = OFS_CPU + NUM_CPU;
    localparam int TOTAL    = OFS_SE + NUM_SE;

    pin_set_t pins_raw, pins_sync;
    park_mode_e park;

    logic [NUM_PCIE-1:0] pcie_want;
    logic [NUM_CPU-1:0]  cpu_want_v;
    logic [TOTAL-1:0]    want_all, run_all;
    logic                park_hiz;

    assign pins_raw = '{req_a_n: req_a_n, req_b_n: req_b_n, cpu_stop_n: cpu_stop_n};
    assign park     = park_mode_e'(park_mode);
    assign park_hiz = (park == PARK_HIZ);

    gate_sync #(
        .WIDTH   (PIN_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) pin_sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_sync)
    );

    pcie_want_gen #(.LANES(NUM_PCIE)) pcie_want_i (
        .sel_a     (pcie_sel_a),
        .sel_b     (pcie_sel_b),
        .master_en (pcie_master_en),
        .pin_a_n   (pins_sync.req_a_n),
        .pin_b_n   (pins_sync.req_b_n),
        .want      (pcie_want),
        .conflict  (sel_conflict)
    );

    cpu_want_gen #(.PAIRS(NUM_CPU)) cpu_want_i (
        .en       (cpu_en),
        .stop_en  (cpu_stop_en),
        .stop_now (~pins_sync.cpu_stop_n),
        .want     (cpu_want_v)
    );

    assign want_all = {se_en, cpu_want_v, gfx_en, pcie_want};

    gate_run_reg #(.WIDTH(TOTAL)) run_reg_i (
        .clk    (clk),
        .rst    (rst),
        .window (gate_window),
        .want   (want_all),
        .run    (run_all)
    );

    assign pcie_run = run_all[OFS_PCIE +: NUM_PCIE];
    assign gfx_run  = run_all[OFS_GFX  +: NUM_GFX];
    assign cpu_run  = run_all[OFS_CPU  +: NUM_CPU];
    assign se_run   = run_all[OFS_SE   +: NUM_SE];

    assign pcie_hiz = ~pcie_run & {NUM_PCIE{park_hiz}};
    assign gfx_hiz  = ~gfx_run  & {NUM_GFX{park_hiz}};
    assign cpu_hiz  = ~cpu_run  & {NUM_CPU{park_hiz}};

    // R3: a lane with its master enable off never runs after the next update
    p_master_off_r3: assert property (@(posedge clk) disable iff (rst)
        gate_window |=> ((pcie_run & ~$past(pcie_master_en)) == '0));

    // R4: graphics outputs track their enables only
    p_gfx_follow_r4: assert property (@(posedge clk) disable iff (rst)
        gate_window |=> (gfx_run == $past(gfx_en)));

    // R6: a free-running enabled CPU pair 1 keeps running
    p_cpu_free_r6: assert property (@(posedge clk) disable iff (rst)
        (gate_window && !cpu_stop_en[0] && cpu_en[1]) |=> cpu_run[1]);

    // R7: single-ended outputs track their enables only
    p_se_follow_r7: assert property (@(posedge clk) disable iff (rst)
        gate_window |=> (se_run == $past(se_en)));
endmodule

// File: tb/clkreq_gate_ctrl_tb_top.sv
module clkreq_gate_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    typedef struct packed {
        logic [5:0] sel_a;
        logic [5:0] sel_b;
        logic [5:0] master;
        logic       a_n;
        logic       b_n;
        logic [5:0] exp_run;
        logic       exp_conf;
    } vec_t;

    // R1, R2, R3, R8 steady-state vectors (lane i = bit i)
    localparam vec_t VECS [NVEC] = '{
        '{6'h03, 6'h00, 6'h3F, 1'b0, 1'b1, 6'h3F, 1'b0},
        '{6'h03, 6'h00, 6'h3F, 1'b1, 1'b1, 6'h3C, 1'b0},
        '{6'h00, 6'h30, 6'h3F, 1'b1, 1'b1, 6'h0F, 1'b0},
        '{6'h00, 6'h30, 6'h3F, 1'b1, 1'b0, 6'h3F, 1'b0},
        '{6'h01, 6'h01, 6'h3F, 1'b0, 1'b1, 6'h3E, 1'b1},
        '{6'h01, 6'h01, 6'h3F, 1'b1, 1'b0, 6'h3E, 1'b1},
        '{6'h01, 6'h01, 6'h3F, 1'b0, 1'b0, 6'h3F, 1'b1},
        '{6'h00, 6'h00, 6'h15, 1'b1, 1'b1, 6'h15, 1'b0},
        '{6'h3F, 6'h00, 6'h00, 1'b0, 1'b1, 6'h00, 1'b0}
    };

    logic clk = 1'b0;
    logic rst, gate_window, req_a_n, req_b_n, cpu_stop_n, park_mode;
    logic [5:0] pcie_sel_a, pcie_sel_b, pcie_master_en, pcie_run, pcie_hiz;
    logic [1:0] gfx_en, gfx_run, gfx_hiz, cpu_stop_en;
    logic [2:0] cpu_en, cpu_run, cpu_hiz;
    logic [4:0] se_en, se_run;
    logic       sel_conflict;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkreq_gate_ctrl dut_i (
        .clk(clk), .rst(rst), .gate_window(gate_window),
        .req_a_n(req_a_n), .req_b_n(req_b_n), .cpu_stop_n(cpu_stop_n),
        .pcie_sel_a(pcie_sel_a), .pcie_sel_b(pcie_sel_b), .pcie_master_en(pcie_master_en),
        .gfx_en(gfx_en), .park_mode(park_mode), .cpu_en(cpu_en), .cpu_stop_en(cpu_stop_en),
        .se_en(se_en), .pcie_run(pcie_run), .pcie_hiz(pcie_hiz), .gfx_run(gfx_run),
        .gfx_hiz(gfx_hiz), .cpu_run(cpu_run), .cpu_hiz(cpu_hiz), .se_run(se_run),
        .sel_conflict(sel_conflict)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; gate_window = 1'b1;
        req_a_n = 1'b1; req_b_n = 1'b1; cpu_stop_n = 1'b1;
        pcie_sel_a = '0; pcie_sel_b = '0; pcie_master_en = 6'h3F;
        gfx_en = 2'b11; park_mode = 1'b0; cpu_en = 3'b111; cpu_stop_en = 2'b11;
        se_en = 5'h1F;
        tick(3);
        // R11: reset state
        chk("R11 pcie_run in reset", pcie_run, 6'h00);
        chk("R11 gfx/cpu/se run in reset", {gfx_run, cpu_run, se_run}, 10'h000);
        chk("R5 hiz with park driven", {pcie_hiz, gfx_hiz, cpu_hiz}, 11'h000);
        rst = 1'b0;
        tick(1);
        chk("R11 first open edge", {pcie_run, gfx_run, cpu_run, se_run}, 16'hFFFF);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            pcie_sel_a = VECS[v].sel_a; pcie_sel_b = VECS[v].sel_b;
            pcie_master_en = VECS[v].master;
            req_a_n = VECS[v].a_n; req_b_n = VECS[v].b_n;
            tick(4);
            checks++;
            if (pcie_run !== VECS[v].exp_run) begin
                errors++;
                $display("FAIL R1/R2/R3 vec %0d pcie_run: actual 0x%0h expected 0x%0h",
                         v, pcie_run, VECS[v].exp_run);
            end
            chk("R8 sel_conflict", sel_conflict, VECS[v].exp_conf);
        end

        // R5: park mode selects high impedance for stopped outputs only
        pcie_sel_a = '0; pcie_sel_b = '0; pcie_master_en = 6'h3E;
        cpu_en = 3'b110; park_mode = 1'b1;
        tick(2);
        chk("R5 pcie_hiz parked", pcie_hiz, 6'h01);
        chk("R5 cpu_hiz parked", cpu_hiz, 3'b001);
        park_mode = 1'b0;
        tick(1);
        chk("R5 pcie_hiz driven", pcie_hiz, 6'h00);

        // R4: graphics ignore request pins
        pcie_sel_a = 6'h3F; pcie_sel_b = 6'h3F; req_a_n = 1'b1; req_b_n = 1'b1;
        gfx_en = 2'b10;
        tick(4);
        chk("R4 gfx_run with pins stopping", gfx_run, 2'b10);
        req_a_n = 1'b0; req_b_n = 1'b0; gfx_en = 2'b01;
        tick(4);
        chk("R4 gfx_run with pins requesting", gfx_run, 2'b01);

        // R6: CPU stop with per-pair stop enables
        cpu_en = 3'b111; cpu_stop_en = 2'b01; cpu_stop_n = 1'b0;
        tick(4);
        chk("R6 pair 2 free-running", cpu_run, 3'b100);
        cpu_stop_en = 2'b11;
        tick(2);
        chk("R6 all stoppable", cpu_run, 3'b000);
        cpu_stop_n = 1'b1;
        tick(4);
        chk("R6 stop released", cpu_run, 3'b111);
        cpu_en = 3'b101;
        tick(2);
        chk("R6 enable bits", cpu_run, 3'b101);

        // R7: single-ended enables
        se_en = 5'b10110;
        tick(2);
        chk("R7 se_run", se_run, 5'b10110);

        // R9: three-edge latency from pin to run
        pcie_sel_a = 6'h01; pcie_sel_b = 6'h00; pcie_master_en = 6'h3F; req_a_n = 1'b0;
        tick(4);
        chk("R9 lane0 running", pcie_run[0], 1'b1);
        req_a_n = 1'b1;
        tick(2);
        chk("R9 lane0 after two edges", pcie_run[0], 1'b1);
        tick(1);
        chk("R9 lane0 after three edges", pcie_run[0], 1'b0);

        // R10: closed window holds every output
        gate_window = 1'b0; req_a_n = 1'b0; se_en = 5'b00000;
        tick(5);
        chk("R10 lane0 held", pcie_run[0], 1'b0);
        chk("R10 se_run held", se_run, 5'b10110);
        gate_window = 1'b1;
        tick(1);
        chk("R10 lane0 on reopen", pcie_run[0], 1'b1);
        chk("R10 se_run on reopen", se_run, 5'b00000);

        finish_run();
    end
endmodule